// File: doc/BRIEF.md
# Scalable Digit-Serial Gaussian Normal Basis Field Multiplier

This core forms a product in GF(2^M) with one small D×D Hankel matrix-vector multiplier that is used over and over. The field elements are taken to be already mapped into a length-P vector, where P = M·T + 1 is prime and T is the Gaussian normal basis type. The caller loads two operand sets into the core. The first is a bank of Hankel digits, each 2D−1 bits wide. The second is a bank of plain operand digits, each D bits wide. The caller then pulses `start`.

The core steps through only the result digits that are needed. It makes N·K Hankel multiplications, where N = P/D. Each product is steered into the accumulator that belongs to its result digit. After each result row, the Hankel bank rotates by one digit. No modular reduction stage follows the accumulators. When the last product has been folded in, `done` pulses for one cycle and the result digits stay on `c_out` until the next accepted start.

Top module: `gauss_nb_mult`

## Requirements
- R1: After a synchronous reset, `done` is 0 and every bit of `c_out` is 0.
- R2: A `start` that is accepted (the core is idle and no product is still in flight) loads both operand banks from `h_load` and `b_load`. At the same edge it clears all accumulators, so `c_out` reads 0 for the next two cycles.
- R3: Result digit i (`c_out[i*D +: D]`) is the XOR over j = 0..N−1 of hank(Hdigit(i+j), Bdigit(j)). Hdigit(q) is `h_load[q*(2D-1) +: 2D-1]` and Bdigit(j) is `b_load[j*D +: D]`. Bit r of hank(h, b) is the XOR over c = 0..D−1 of h[r+c] AND b[c].
- R4: The derived sizes are P = M·T+1 and N = P/D. K is ceil(M·T/(2D)) when M is even and ceil((M·T−T+2)/(2D)) when M is odd, with a minimum of 1. The Hankel bank holds N+K−1 digits.
- R5: `done` is high for exactly one cycle. That cycle comes N·K+1 rising edges after the edge that accepted `start`.
- R6: A `start` seen while products are still being issued or drained is ignored. It has no effect on the result or on the timing of `done`.
- R7: Outside a run, `c_out` holds its last value, whatever `h_load`, `b_load` do.
- R8: Changes to `h_load` and `b_load` after the accepting edge have no effect on the run in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Start request, sampled on rising edges |
| h_load | input | (N+K−1)·(2D−1) | Hankel operand digits, digit q in bits q·(2D−1) upward |
| b_load | input | N·D | Second operand digits, digit j in bits j·D upward |
| c_out | output | K·D | Result digits, digit i in bits i·D upward (registered) |
| done | output | 1 | One-cycle pulse when the result is complete (registered) |

## Verification
Time is counted in rising edges from the edge that accepts `start`. `c_out` is due to read zero after edges 0 and 1. `done`, together with the final `c_out`, is due after edge N·K+1. The result must then hold until the next accepted start. The bench model counts edges in the same way, takes its expected product from the operands latched at the accepting edge, and compares `done` and `c_out` on every falling edge with the value due for that edge count. The scenarios cover a start that lands during issue or drain, a start that lands in the done cycle itself, and operand changes during a run. They run at D=1 (N=7, K=3) and at D=7 (N=1, K=1).

// File: rtl/gauss_nb_pkg.sv
package gauss_nb_pkg;

  function automatic int cdiv(input int a, input int b);
    return (a + b - 1) / b;
  endfunction

  // index width that never collapses to zero bits
  function automatic int iw(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

  // number of result digits that must be formed
  function automatic int half_digits(input int m, input int t, input int d);
    int num;
    int k;
    num = ((m % 2) == 0) ? (m * t) : (m * t - t + 2);
    k = cdiv(num, 2 * d);
    return (k < 1) ? 1 : k;
  endfunction

endpackage

// File: rtl/gauss_nb_ctrl.sv
module gauss_nb_ctrl #(
  parameter int N  = 7,
  parameter int K  = 3,
  parameter int JW = 3,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic          drain,
  output logic          accept,
  output logic          busy,
  output logic [IW-1:0] row,
  output logic [JW-1:0] col,
  output logic          shift,
  output logic          last
);
  logic row_end;

  assign accept  = start && !busy && !drain;
  assign row_end = busy && (col == JW'(N - 1));
  assign last    = row_end && (row == IW'(K - 1));
  assign shift   = row_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      row  <= '0;
      col  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      row  <= '0;
      col  <= '0;
    end else if (busy) begin
      if (row_end) begin
        col <= '0;
        if (last) busy <= 1'b0;
        else      row  <= row + 1'b1;
      end else begin
        col <= col + 1'b1;
      end
    end
  end
endmodule

// File: rtl/gauss_nb_opbank.sv
module gauss_nb_opbank #(
  parameter int N  = 7,
  parameter int NH = 9,
  parameter int D  = 1,
  parameter int JW = 3,
  parameter int QW = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    load,
  input  logic                    shift,
  input  logic [NH*(2*D-1)-1:0]   h_load,
  input  logic [N*D-1:0]          b_load,
  input  logic [JW-1:0]           sel,
  output logic [2*D-2:0]          h_sel,
  output logic [D-1:0]            b_sel
);
  localparam int HW = 2 * D - 1;

  logic [HW-1:0] hank_q [NH];
  logic [D-1:0]  opb_q  [N];

  // Hankel bank: load, or rotate down one digit per finished row
  for (genvar q = 0; q < NH; q++) begin : g_h
    always_ff @(posedge clk) begin
      if (rst)        hank_q[q] <= '0;
      else if (load)  hank_q[q] <= h_load[q*HW +: HW];
      else if (shift) hank_q[q] <= hank_q[(q + 1) % NH];
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_b
    always_ff @(posedge clk) begin
      if (rst)       opb_q[j] <= '0;
      else if (load) opb_q[j] <= b_load[j*D +: D];
    end
  end

  assign h_sel = hank_q[QW'(sel)];
  assign b_sel = opb_q[sel];
endmodule

// File: rtl/gauss_nb_hankel.sv
module gauss_nb_hankel #(
  parameter int D  = 1,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_vld,
  input  logic [IW-1:0] in_row,
  input  logic          in_last,
  input  logic [2*D-2:0] h,
  input  logic [D-1:0]  b,
  output logic          out_vld,
  output logic [IW-1:0] out_row,
  output logic          out_last,
  output logic [D-1:0]  y
);
  logic [D-1:0] y_c;

  // row r of the Hankel matrix is the window h[r +: D]
  for (genvar r = 0; r < D; r++) begin : g_row
    assign y_c[r] = ^(h[r +: D] & b);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_vld  <= 1'b0;
      out_row  <= '0;
      out_last <= 1'b0;
      y        <= '0;
    end else begin
      out_vld  <= in_vld;
      out_row  <= in_row;
      out_last <= in_vld && in_last;
      y        <= in_vld ? y_c : '0;
    end
  end
endmodule

// File: rtl/gauss_nb_accum.sv
module gauss_nb_accum #(
  parameter int K  = 3,
  parameter int D  = 1,
  parameter int IW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clear,
  input  logic          in_vld,
  input  logic [IW-1:0] in_row,
  input  logic          in_last,
  input  logic [D-1:0]  y,
  output logic [K*D-1:0] c_flat,
  output logic          done
);
  // switch: each product lands in the accumulator named by its row tag
  for (genvar i = 0; i < K; i++) begin : g_acc
    always_ff @(posedge clk) begin
      if (rst || clear)
        c_flat[i*D +: D] <= '0;
      else if (in_vld && (in_row == IW'(i)))
        c_flat[i*D +: D] <= c_flat[i*D +: D] ^ y;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) done <= 1'b0;
    else     done <= in_vld && in_last;
  end
endmodule

// File: rtl/gauss_nb_mult.sv
module gauss_nb_mult
  import gauss_nb_pkg::*;
#(
  parameter int M = 2,
  parameter int T = 3,
  parameter int D = 1,
  localparam int P  = M * T + 1,
  localparam int N  = P / D,
  localparam int K  = half_digits(M, T, D),
  localparam int NH = N + K - 1,
  localparam int HW = 2 * D - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [NH*HW-1:0]  h_load,
  input  logic [N*D-1:0]    b_load,
  output logic [K*D-1:0]    c_out,
  output logic              done
);
  localparam int JW = iw(N);
  localparam int IW = iw(K);
  localparam int QW = iw(NH);

  logic          accept, busy, shift, last;
  logic [IW-1:0] row;
  logic [JW-1:0] col;
  logic [HW-1:0] h_sel;
  logic [D-1:0]  b_sel;
  logic          pv, p_last;
  logic [IW-1:0] p_row;
  logic [D-1:0]  prod;

  gauss_nb_ctrl #(.N(N), .K(K), .JW(JW), .IW(IW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .drain(pv),
    .accept(accept), .busy(busy), .row(row), .col(col),
    .shift(shift), .last(last)
  );

  gauss_nb_opbank #(.N(N), .NH(NH), .D(D), .JW(JW), .QW(QW)) u_bank (
    .clk(clk), .rst(rst), .load(accept), .shift(shift),
    .h_load(h_load), .b_load(b_load), .sel(col),
    .h_sel(h_sel), .b_sel(b_sel)
  );

  gauss_nb_hankel #(.D(D), .IW(IW)) u_hank (
    .clk(clk), .rst(rst), .in_vld(busy), .in_row(row), .in_last(last),
    .h(h_sel), .b(b_sel),
    .out_vld(pv), .out_row(p_row), .out_last(p_last), .y(prod)
  );

  gauss_nb_accum #(.K(K), .D(D), .IW(IW)) u_acc (
    .clk(clk), .rst(rst), .clear(accept),
    .in_vld(pv), .in_row(p_row), .in_last(p_last), .y(prod),
    .c_flat(c_out), .done(done)
  );
endmodule

// File: rtl/gauss_nb_mult_chk.sv
module gauss_nb_mult_chk #(
  parameter int NK = 21,
  parameter int CW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          accept,
  input logic          busy,
  input logic          pv,
  input logic          done,
  input logic [CW-1:0] c_out
);
  logic        run;
  logic [31:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      run <= 1'b0;
      cnt <= '0;
    end else if (accept) begin
      run <= 1'b1;
      cnt <= '0;
    end else if (run) begin
      cnt <= cnt + 1;
      if (done) run <= 1'b0;
    end
  end

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);
  // R5
  done_timing_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (run && cnt == 32'(NK + 1)));
  // R5
  done_due_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt == 32'(NK + 1)) |-> done);
  // R2
  clear_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> (c_out == '0));
  // R6
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (run && cnt <= 32'(NK)) |-> !accept);
  // R7
  hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !pv && !accept) |=> $stable(c_out));
  // R3
  issue_order_chk: assert property (@(posedge clk) disable iff (rst)
    pv |-> $past(busy));
endmodule

bind gauss_nb_mult gauss_nb_mult_chk #(.NK(N * K), .CW(K * D)) u_chk (
  .clk(clk), .rst(rst), .accept(accept), .busy(busy),
  .pv(pv), .done(done), .c_out(c_out)
);

// File: tb/sim_lane.sv
module sim_lane #(
  parameter int M = 2,
  parameter int T = 3,
  parameter int D = 1
) (
  input logic clk,
  input logic rst
);
  localparam int P   = M * T + 1;
  localparam int N   = P / D;
  localparam int KN  = ((M % 2) == 0) ? (M * T) : (M * T - T + 2);
  localparam int K0  = (KN + 2 * D - 1) / (2 * D);
  localparam int K   = (K0 < 1) ? 1 : K0;
  localparam int NH  = N + K - 1;
  localparam int HW  = 2 * D - 1;
  localparam int NK  = N * K;
  localparam int HB  = NH * HW;
  localparam int BB  = N * D;
  localparam int CB  = K * D;

  logic          start = 1'b0;
  logic [HB-1:0] h_in  = '0;
  logic [BB-1:0] b_in  = '0;
  logic [CB-1:0] c_out;
  logic          done;

  gauss_nb_mult #(.M(M), .T(T), .D(D)) u0 (
    .clk(clk), .rst(rst), .start(start), .h_load(h_in), .b_load(b_in),
    .c_out(c_out), .done(done)
  );

  int    errs   = 0;
  int    checks = 0;
  bit    fin    = 0;
  string scen   = "idle";
  int    mcnt   = -1;
  logic [CB-1:0] exp_c = '0;

  function automatic logic [CB-1:0] ref_prod(input logic [HB-1:0] h, input logic [BB-1:0] b);
    logic [CB-1:0] r;
    r = '0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < N; j++)
        for (int rr = 0; rr < D; rr++)
          for (int cc = 0; cc < D; cc++)
            r[i*D+rr] = r[i*D+rr] ^ (h[(i+j)*HW+rr+cc] & b[j*D+cc]);
    return r;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] got, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s (%s, D=%0d) got %0h expected %0h", req, scen, D, got, expv);
    end
  endtask

  // edge-count reference model
  always @(posedge clk) begin
    if (rst) begin
      mcnt  = -1;
      exp_c = '0;
    end else if (mcnt >= 0 && mcnt <= NK) begin
      mcnt++;
    end else if (start) begin
      mcnt  = 0;
      exp_c = ref_prod(h_in, b_in);
    end else begin
      mcnt = -1;
    end
  end

  always @(negedge clk) begin
    if (!rst) begin
      chk(done === (mcnt == NK + 1), "R4/R5 done", 64'(done), 64'(mcnt == NK + 1));
      if (mcnt == 0 || mcnt == 1)
        chk(c_out === '0, "R2 clear", 64'(c_out), 64'd0);
      else if (mcnt == NK + 1)
        chk(c_out === exp_c, "R3 product", 64'(c_out), 64'(exp_c));
      else if (mcnt < 0)
        chk(c_out === exp_c, "R7 hold", 64'(c_out), 64'(exp_c));
    end
  end

  task automatic go(input logic [HB-1:0] h, input logic [BB-1:0] b);
    @(negedge clk);
    h_in = h; b_in = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (NK + 3) @(negedge clk);
  endtask

  initial begin
    wait (rst == 1'b0);
    @(negedge clk);
    scen = "R1 reset";
    chk(done === 1'b0 && c_out === '0, "R1 reset", 64'({done, c_out}), 64'd0);

    scen = "R3 ones";
    go('1, '1);
    scen = "R3 single";
    go(HB'(1), BB'(1));
    scen = "R3 zero";
    go('0, '1);
    scen = "R3 random";
    for (int n = 0; n < 6; n++) go(HB'($urandom), BB'($urandom));

    // start while issuing or draining
    scen = "R6 busy start";
    @(negedge clk);
    h_in = HB'($urandom); b_in = BB'($urandom); start = 1'b1;
    @(negedge clk);
    h_in = HB'($urandom); b_in = BB'($urandom);
    repeat (NK) @(negedge clk);
    start = 1'b0;
    repeat (NK + 3) @(negedge clk);

    // operand change after acceptance
    scen = "R8 operand change";
    @(negedge clk);
    h_in = HB'($urandom); b_in = BB'($urandom); start = 1'b1;
    @(negedge clk);
    start = 1'b0; h_in = ~h_in; b_in = ~b_in;
    repeat (NK + 3) @(negedge clk);

    // new start issued in the done cycle
    scen = "R6 back-to-back";
    @(negedge clk);
    h_in = HB'($urandom); b_in = BB'($urandom); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (done !== 1'b1) @(negedge clk);
    h_in = HB'($urandom); b_in = BB'($urandom); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (NK + 3) @(negedge clk);

    // idle with moving inputs
    scen = "R7 idle inputs";
    for (int n = 0; n < 5; n++) begin
      @(negedge clk);
      h_in = HB'($urandom); b_in = BB'($urandom);
    end
    repeat (3) @(negedge clk);
    fin = 1'b1;
  end
endmodule

// File: tb/sim_gauss_nb_mult.sv
module sim_gauss_nb_mult;
  logic clk = 1'b0;
  logic rst = 1'b1;
  bit   timeout = 0;

  always #10 clk = ~clk;

  sim_lane #(.M(2), .T(3), .D(1)) lane_a (.clk(clk), .rst(rst));
  sim_lane #(.M(2), .T(3), .D(7)) lane_b (.clk(clk), .rst(rst));

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
  end

  initial begin
    int errs;
    int total;
    fork
      wait (lane_a.fin && lane_b.fin);
      begin
        repeat (100000) @(posedge clk);
        timeout = 1;
      end
    join_any
    errs  = lane_a.errs + lane_b.errs;
    total = lane_a.checks + lane_b.checks;
    if (timeout) begin
      errs++;
      total++;
      $display("FAIL watchdog expired before both lanes finished");
    end
    $display("Result: errors=%0d of %0d checks", errs, total);
    $finish;
  end
endmodule